// File: doc/BRIEF.md
# Host Command Mailbox with Scratch-Mode Handshake

This block is the device end of a byte-wide, keyboard-controller style host link. The host sees two port addresses. One is a data port. The other is a control port: a write to it is a command and a read returns status. Each direction holds a single byte. The input side fills when the host writes to either port. It drains a configurable number of cycles later, when the device consumes the byte. The output side is filled either by local logic or by the built-in command decoder, and it drains when the host reads the data port.

The decoder handles two control-port commands itself:

- 0xB4 puts the device into scratch-RAM execution mode. It answers with the byte 0xFA in the output buffer.
- 0xFE returns the device to flash execution. If the device is already in flash mode, 0xFE is reported as a system reset request.

All other consumed bytes are handed to local logic through a one-cycle receive strobe. Local logic posts reply bytes through a ready/valid pair.

Top module: `kbm_mailbox`

## Requirements
- R1: A host read of the control port (default 0x64) returns status: bit 0 output-full, bit 1 input-full, bit 3 set when the last accepted host write went to the control port, bit 5 sticky overrun, all other bits 0. The read changes no flag.
- R2: A host read of the data port (default 0x60) returns the output byte and clears output-full at the end of that cycle.
- R3: A host write to the data or control port while input-full is clear stores the byte and sets input-full. Writes to any other address have no effect.
- R4: Input-full stays set for exactly CONSUME_DLY cycles after the accepting edge and then clears as the byte is consumed.
- R5: A host write to either port while input-full is set is dropped. It sets the overrun flag, which stays set until reset.
- R6: A consumed control-port byte 0xB4 sets scratch_mode and loads 0xFA into the output buffer with output-full set, replacing any earlier content. A repeat while already in scratch mode gives the same reply and leaves scratch_mode set.
- R7: A consumed 0xFE while in scratch mode clears scratch_mode, posts no reply and raises no reset request.
- R8: A consumed 0xFE while in flash mode pulses sys_rst_req for one cycle and leaves scratch_mode clear.
- R9: Every consumed byte other than the two special commands produces a one-cycle loc_rx_valid carrying the byte, with loc_rx_cmd set for control-port writes. The special commands never appear there.
- R10: loc_tx_ready is high only while output-full is clear and no 0xFA reply is being loaded. A post with loc_tx_valid and loc_tx_ready loads the byte and sets output-full. A post without ready is dropped.
- R11: When a buffer load and a host data-port read fall in the same cycle, the load wins: output-full stays set with the new byte, and the read returns the old byte.
- R12: After reset all flags are clear, scratch_mode is 0 and sys_rst_req is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_stb | input | 1 | Host access strobe, one cycle per access |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | AW | Host port address |
| hst_wdata | input | DW | Host write byte |
| hst_rdata | output | DW | Host read data, valid in the strobe cycle |
| loc_rx_valid | output | 1 | One-cycle strobe: consumed byte for local logic |
| loc_rx_byte | output | DW | Byte delivered with loc_rx_valid |
| loc_rx_cmd | output | 1 | Byte came through the control port |
| loc_tx_valid | input | 1 | Local logic offers a reply byte |
| loc_tx_byte | input | DW | Reply byte |
| loc_tx_ready | output | 1 | Output buffer can take a local byte |
| scratch_mode | output | 1 | Device is in scratch-RAM execution mode |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the completion of a 0xB4 command and a host data-port read. The bench provokes this by issuing the read exactly CONSUME_DLY cycles after the command write. In the same cycle it offers a local reply byte. It then judges three things: the read returns the stale byte, 0xFA survives with output-full set, and the local byte is refused.

The second pair is a host write and a still-full input buffer. The bench provokes this with back-to-back writes and checks that the first byte reaches local logic untouched and that overrun appears. A behavioural model compares every output on every cycle.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
   localparam int ST_OBF = 0;
   localparam int ST_IBF = 1;
   localparam int ST_CMD = 3;
   localparam int ST_OVR = 5;
   localparam logic [7:0] CMD_ENTER_RAM = 8'hB4;
   localparam logic [7:0] CMD_LEAVE_RAM = 8'hFE;
   localparam logic [7:0] REPLY_ACK     = 8'hFA;
endpackage

// File: rtl/kbm_host_dec.sv
module kbm_host_dec #(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter logic [AW-1:0] DATA_ADDR = 'h60,
   parameter logic [AW-1:0] CTRL_ADDR = 'h64
) (
   input  logic          hst_stb,
   input  logic          hst_wr,
   input  logic [AW-1:0] hst_addr,
   input  logic [DW-1:0] status,
   input  logic [DW-1:0] obuf,
   output logic          wr_data,
   output logic          wr_ctrl,
   output logic          rd_data,
   output logic [DW-1:0] hst_rdata
);
   logic hit_data, hit_ctrl, rd_ctrl;

   assign hit_data = hst_stb && (hst_addr == DATA_ADDR);
   assign hit_ctrl = hst_stb && (hst_addr == CTRL_ADDR);
   assign wr_data  = hit_data && hst_wr;
   assign wr_ctrl  = hit_ctrl && hst_wr;
   assign rd_data  = hit_data && !hst_wr;
   assign rd_ctrl  = hit_ctrl && !hst_wr;

   always_comb begin
      if (rd_ctrl)      hst_rdata = status;
      else if (rd_data) hst_rdata = obuf;
      else              hst_rdata = '0;
   end
endmodule

// File: rtl/kbm_inbuf.sv
module kbm_inbuf #(
   parameter int DW = 8,
   parameter int CONSUME_DLY = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_data,
   input  logic          wr_ctrl,
   input  logic [DW-1:0] wdata,
   output logic          ibf,
   output logic [DW-1:0] byte_q,
   output logic          cmd_q,
   output logic          ovr,
   output logic          consume
);
   localparam int CW = (CONSUME_DLY > 1) ? $clog2(CONSUME_DLY) : 1;

   logic any_wr, accept, last;

   assign any_wr  = wr_data || wr_ctrl;
   assign accept  = any_wr && !ibf;
   assign consume = ibf && last;

   generate
      if (CONSUME_DLY == 1) begin : g_nodly
         assign last = 1'b1;
      end else begin : g_cnt
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n)                  cnt <= '0;
            else if (accept)             cnt <= CW'(CONSUME_DLY - 1);
            else if (ibf && cnt != '0)   cnt <= cnt - 1'b1;
         end
         assign last = (cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ibf    <= 1'b0;
         byte_q <= '0;
         cmd_q  <= 1'b0;
         ovr    <= 1'b0;
      end else begin
         if (accept) begin
            ibf    <= 1'b1;
            byte_q <= wdata;
            cmd_q  <= wr_ctrl;
         end else if (consume) begin
            ibf    <= 1'b0;
         end
         if (any_wr && ibf) ovr <= 1'b1;
      end
   end
endmodule

// File: rtl/kbm_cmd_dec.sv
module kbm_cmd_dec #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          consume,
   input  logic [DW-1:0] byte_q,
   input  logic          cmd_q,
   output logic          ack_load,
   output logic          pass_valid,
   output logic          scratch_mode,
   output logic          rst_req
);
   import kbm_pkg::*;

   logic is_enter, is_leave;

   assign is_enter   = consume && cmd_q && (byte_q == DW'(CMD_ENTER_RAM));
   assign is_leave   = consume && cmd_q && (byte_q == DW'(CMD_LEAVE_RAM));
   assign ack_load   = is_enter;
   assign pass_valid = consume && !is_enter && !is_leave;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scratch_mode <= 1'b0;
         rst_req      <= 1'b0;
      end else begin
         rst_req <= is_leave && !scratch_mode;
         if (is_enter)      scratch_mode <= 1'b1;
         else if (is_leave) scratch_mode <= 1'b0;
      end
   end
endmodule

// File: rtl/kbm_outbuf.sv
module kbm_outbuf #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ack_load,
   input  logic [DW-1:0] ack_byte,
   input  logic          tx_valid,
   input  logic [DW-1:0] tx_byte,
   input  logic          rd_data,
   output logic          tx_ready,
   output logic          obf,
   output logic [DW-1:0] obuf
);
   assign tx_ready = !obf && !ack_load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         obf  <= 1'b0;
         obuf <= '0;
      end else if (ack_load) begin
         obf  <= 1'b1;
         obuf <= ack_byte;
      end else if (tx_valid && tx_ready) begin
         obf  <= 1'b1;
         obuf <= tx_byte;
      end else if (rd_data) begin
         obf  <= 1'b0;
      end
   end
endmodule

// File: rtl/kbm_mailbox.sv
module kbm_mailbox #(
   parameter int AW = 8,
   parameter int DW = 8,
   parameter logic [AW-1:0] DATA_ADDR = 'h60,
   parameter logic [AW-1:0] CTRL_ADDR = 'h64,
   parameter int CONSUME_DLY = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hst_stb,
   input  logic          hst_wr,
   input  logic [AW-1:0] hst_addr,
   input  logic [DW-1:0] hst_wdata,
   output logic [DW-1:0] hst_rdata,
   output logic          loc_rx_valid,
   output logic [DW-1:0] loc_rx_byte,
   output logic          loc_rx_cmd,
   input  logic          loc_tx_valid,
   input  logic [DW-1:0] loc_tx_byte,
   output logic          loc_tx_ready,
   output logic          scratch_mode,
   output logic          sys_rst_req
);
   import kbm_pkg::*;

   if (DW < 8) begin : g_bad_dw
      $error("kbm_mailbox: DW must be at least 8");
   end
   if (CONSUME_DLY < 1) begin : g_bad_dly
      $error("kbm_mailbox: CONSUME_DLY must be at least 1");
   end
   if (DATA_ADDR == CTRL_ADDR) begin : g_bad_addr
      $error("kbm_mailbox: port addresses must differ");
   end

   logic          wr_data, wr_ctrl, rd_data;
   logic          ibf, cmd_q, ovr, consume;
   logic [DW-1:0] byte_q;
   logic          ack_load, pass_valid;
   logic          obf;
   logic [DW-1:0] obuf_q;
   logic [DW-1:0] status;

   always_comb begin
      status         = '0;
      status[ST_OBF] = obf;
      status[ST_IBF] = ibf;
      status[ST_CMD] = cmd_q;
      status[ST_OVR] = ovr;
   end

   kbm_host_dec #(.AW(AW), .DW(DW), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_dec (
      .hst_stb  (hst_stb),
      .hst_wr   (hst_wr),
      .hst_addr (hst_addr),
      .status   (status),
      .obuf     (obuf_q),
      .wr_data  (wr_data),
      .wr_ctrl  (wr_ctrl),
      .rd_data  (rd_data),
      .hst_rdata(hst_rdata)
   );

   kbm_inbuf #(.DW(DW), .CONSUME_DLY(CONSUME_DLY)) u_in (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_data(wr_data),
      .wr_ctrl(wr_ctrl),
      .wdata  (hst_wdata),
      .ibf    (ibf),
      .byte_q (byte_q),
      .cmd_q  (cmd_q),
      .ovr    (ovr),
      .consume(consume)
   );

   kbm_cmd_dec #(.DW(DW)) u_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .consume     (consume),
      .byte_q      (byte_q),
      .cmd_q       (cmd_q),
      .ack_load    (ack_load),
      .pass_valid  (pass_valid),
      .scratch_mode(scratch_mode),
      .rst_req     (sys_rst_req)
   );

   kbm_outbuf #(.DW(DW)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_load(ack_load),
      .ack_byte(DW'(REPLY_ACK)),
      .tx_valid(loc_tx_valid),
      .tx_byte (loc_tx_byte),
      .rd_data (rd_data),
      .tx_ready(loc_tx_ready),
      .obf     (obf),
      .obuf    (obuf_q)
   );

   assign loc_rx_valid = pass_valid;
   assign loc_rx_byte  = byte_q;
   assign loc_rx_cmd   = cmd_q;
endmodule

// File: rtl/kbm_mailbox_chk.sv
module kbm_mailbox_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ibf,
   input logic          obf,
   input logic          ovr,
   input logic [DW-1:0] obuf_q,
   input logic          scratch_mode,
   input logic          sys_rst_req,
   input logic          loc_rx_valid,
   input logic          loc_tx_ready
);
   import kbm_pkg::*;

   p_consume_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      loc_rx_valid |=> !ibf);

   p_rx_from_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      loc_rx_valid |-> ibf);

   p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> ovr);

   p_enter_reply_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scratch_mode) |-> (obf && obuf_q == DW'(REPLY_ACK)));

   p_reset_only_flash_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> !scratch_mode);

   p_ready_needs_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
      loc_tx_ready |-> !obf);
endmodule

bind kbm_mailbox kbm_mailbox_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ibf         (ibf),
   .obf         (obf),
   .ovr         (ovr),
   .obuf_q      (obuf_q),
   .scratch_mode(scratch_mode),
   .sys_rst_req (sys_rst_req),
   .loc_rx_valid(loc_rx_valid),
   .loc_tx_ready(loc_tx_ready)
);

// File: tb/kbm_mailbox_tb.sv
module kbm_mailbox_tb;
   localparam int DLY = 3;
   localparam logic [7:0] DA = 8'h60;
   localparam logic [7:0] CA = 8'h64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_stb = 1'b0, hst_wr = 1'b0;
   logic [7:0] hst_addr = '0, hst_wdata = '0;
   logic [7:0] hst_rdata;
   logic       loc_rx_valid, loc_rx_cmd, loc_tx_ready, scratch_mode, sys_rst_req;
   logic [7:0] loc_rx_byte;
   logic       loc_tx_valid = 1'b0;
   logic [7:0] loc_tx_byte = '0;

   int n_chk = 0, n_fail = 0;
   int rx_cnt = 0, rst_cnt = 0;
   logic [7:0] last_rx = '0;
   logic       last_rx_cmd = 1'b0;

   always #5 clk = ~clk;

   kbm_mailbox #(.CONSUME_DLY(DLY)) u_dut (
      .clk(clk), .rst_n(rst_n), .hst_stb(hst_stb), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .loc_rx_valid(loc_rx_valid), .loc_rx_byte(loc_rx_byte), .loc_rx_cmd(loc_rx_cmd),
      .loc_tx_valid(loc_tx_valid), .loc_tx_byte(loc_tx_byte), .loc_tx_ready(loc_tx_ready),
      .scratch_mode(scratch_mode), .sys_rst_req(sys_rst_req)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit       m_ibf, m_cmd, m_ovr, m_obf, m_scr, m_rst;
   int       m_left;
   bit [7:0] m_byte, m_obuf;

   function automatic bit m_consume();
      return m_ibf && m_left == 0;
   endfunction
   function automatic bit m_enter();
      return m_consume() && m_cmd && m_byte == 8'hB4;
   endfunction
   function automatic bit m_leave();
      return m_consume() && m_cmd && m_byte == 8'hFE;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ibf = 0; m_cmd = 0; m_ovr = 0; m_obf = 0; m_scr = 0; m_rst = 0;
         m_left = 0; m_byte = 0; m_obuf = 0;
      end else begin
         bit cons, en, lv, wr_hit, rd_d, rdy;
         cons   = m_consume();
         en     = m_enter();
         lv     = m_leave();
         wr_hit = hst_stb && hst_wr && (hst_addr == DA || hst_addr == CA);
         rd_d   = hst_stb && !hst_wr && hst_addr == DA;
         rdy    = !m_obf && !en;
         if (wr_hit && m_ibf) m_ovr = 1;
         if (wr_hit && !m_ibf) begin
            m_ibf = 1; m_byte = hst_wdata; m_cmd = (hst_addr == CA); m_left = DLY - 1;
         end else if (cons) m_ibf = 0;
         else if (m_ibf) m_left--;
         m_rst = lv && !m_scr;
         if (en) m_scr = 1;
         else if (lv) m_scr = 0;
         if (en) begin m_obf = 1; m_obuf = 8'hFA; end
         else if (loc_tx_valid && rdy) begin m_obf = 1; m_obuf = loc_tx_byte; end
         else if (rd_d) m_obf = 0;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      #4;
      if (rst_n) begin
         bit [7:0] st, exp_rd;
         bit ex_rx;
         st = {2'b00, m_ovr, 1'b0, m_cmd, 1'b0, m_ibf, m_obf};
         exp_rd = 8'h00;
         if (hst_stb && !hst_wr && hst_addr == CA) exp_rd = st;
         if (hst_stb && !hst_wr && hst_addr == DA) exp_rd = m_obuf;
         check((hst_addr == CA) ? "R1 status read" : "R2 data read", hst_rdata, exp_rd);
         ex_rx = m_consume() && !m_enter() && !m_leave();
         check("R9 rx strobe", loc_rx_valid, ex_rx);
         if (ex_rx) begin
            check("R9 rx byte", loc_rx_byte, m_byte);
            check("R9 rx cmd flag", loc_rx_cmd, m_cmd);
         end
         check("R10 tx ready", loc_tx_ready, !m_obf && !m_enter());
         check("R6 scratch mode", scratch_mode, m_scr);
         check("R8 reset request", sys_rst_req, m_rst);
         if (loc_rx_valid) begin rx_cnt++; last_rx = loc_rx_byte; last_rx_cmd = loc_rx_cmd; end
         if (sys_rst_req) rst_cnt++;
      end
   end

   task automatic host_write(input logic [7:0] a, input logic [7:0] d);
      hst_stb = 1; hst_wr = 1; hst_addr = a; hst_wdata = d;
      @(negedge clk);
      hst_stb = 0; hst_wr = 0;
   endtask

   task automatic host_read(input logic [7:0] a, output logic [7:0] d);
      hst_stb = 1; hst_wr = 0; hst_addr = a;
      #4 d = hst_rdata;
      @(negedge clk);
      hst_stb = 0;
   endtask

   task automatic post(input logic [7:0] d);
      loc_tx_valid = 1; loc_tx_byte = d;
      @(negedge clk);
      loc_tx_valid = 0;
   endtask

   task automatic settle();
      repeat (DLY + 2) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] s;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      host_read(CA, s); check("R12 status after reset", s, 8'h00);
      check("R12 scratch after reset", scratch_mode, 0);
      check("R12 reset request idle", sys_rst_req, 0);

      // R3 / R4: data write and consume timing
      host_write(DA, 8'h55);
      n = 0;
      host_read(CA, s);
      check("R3 ibf set by data write", s, 8'h02);
      while (s[1] && n < 50) begin n++; host_read(CA, s); end
      check("R4 ibf held cycles", n, DLY);
      check("R9 data byte delivered", last_rx, 8'h55);
      host_write(8'h61, 8'h33);
      host_read(CA, s); check("R3 stray address ignored", s, 8'h00);

      // R5: overrun
      host_write(CA, 8'h12);
      host_write(DA, 8'h99);
      host_read(CA, s); check("R5 overrun status", s, 8'h2A);
      settle();
      check("R5 first byte kept", last_rx, 8'h12);
      check("R9 cmd flag", last_rx_cmd, 1);
      host_read(CA, s); check("R5 overrun sticky", s, 8'h28);

      // R10 / R2: local reply
      post(8'h3C);
      host_read(CA, s); check("R10 obf after post", s, 8'h29);
      post(8'h77);
      host_read(DA, s); check("R10 post while full dropped", s, 8'h3C);
      host_read(CA, s); check("R2 read clears obf", s, 8'h28);

      // R6: enter scratch mode, twice
      host_write(CA, 8'hB4); settle();
      check("R6 scratch set", scratch_mode, 1);
      host_read(DA, s); check("R6 ack byte", s, 8'hFA);
      host_write(CA, 8'hB4); settle();
      check("R6 scratch kept", scratch_mode, 1);
      host_read(DA, s); check("R6 repeat ack", s, 8'hFA);

      // R11: ack load collides with host read and local post
      post(8'h11);
      host_write(CA, 8'hB4);
      repeat (DLY - 1) @(negedge clk);
      hst_stb = 1; hst_wr = 0; hst_addr = DA;
      loc_tx_valid = 1; loc_tx_byte = 8'h22;
      #4 s = hst_rdata;
      check("R11 read returns old byte", s, 8'h11);
      check("R11 ready low during ack", loc_tx_ready, 0);
      @(negedge clk);
      hst_stb = 0; loc_tx_valid = 0;
      host_read(CA, s); check("R11 obf survives read", s, 8'h29);
      host_read(DA, s); check("R11 ack wins", s, 8'hFA);

      // R7 / R8: leaving scratch mode, then stray exit
      host_write(CA, 8'hFE); settle();
      check("R7 scratch cleared", scratch_mode, 0);
      check("R7 no reset request", rst_cnt, 0);
      host_read(CA, s); check("R7 no reply", s, 8'h28);
      host_write(CA, 8'hFE); settle();
      check("R8 reset request pulse", rst_cnt, 1);
      check("R8 mode stays flash", scratch_mode, 0);
      check("R9 specials not delivered", rx_cnt, 2);

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule